// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block keeps one stack-pointer register for each of the four privilege levels (0 to 3) and presents the pointer that is currently active to the datapath. Two pieces of state choose the active pointer: the current privilege level and a one-bit stack select flag. When the flag is clear, the level-0 pointer is active. When it is set, the pointer that belongs to the current level is active. At level 0 the flag has no effect, and the level-0 pointer is always used.

Software changes the select flag with an immediate write of 0 or 1 at any nonzero level. The exception unit sets the level and the flag on exception entry. On exception return it restores both from a saved status word. A single write port updates whichever pointer is active in the cycle of the write. Address arithmetic and overflow checking belong to other blocks.

Top module: `sp_bank_sel`

## Requirements
- R1: After a cycle with `rst` high, all four pointers are zero, the level is 3, the select flag is 1, and `sp_out` is zero.
- R2: When the select flag is 0, `sp_out` shows the level-0 pointer at every level.
- R3: When the select flag is 1 and the level is 1, 2 or 3, `sp_out` shows the pointer of that level.
- R4: At level 0, `sp_out` shows the level-0 pointer whatever the select flag holds.
- R5: A select write (`selw_req` high) at a nonzero level loads `selw_val` into the select flag at the next clock edge.
- R6: A select write at level 0 is ignored, and the select flag keeps its value.
- R7: A pointer write (`spw_en` high) stores `spw_data` into the pointer that is active in that cycle and leaves the other three pointers unchanged.
- R8: Exception entry (`exc_take` high) loads `exc_tgt_lvl` into the level and sets the select flag to 1 at the next edge.
- R9: Exception return (`exc_ret` high) loads the level from `ret_word[2:1]` and the select flag from `ret_word[0]` at the next edge.
- R10: When several of these requests arrive in the same cycle, exception entry wins over exception return, and exception return wins over a select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_take | input | 1 | Exception entry strobe |
| exc_tgt_lvl | input | 2 | Level that the exception is taken to |
| exc_ret | input | 1 | Exception return strobe |
| ret_word | input | 3 | Restored status word: [2:1] level, [0] select flag |
| selw_req | input | 1 | Immediate select-flag write request |
| selw_val | input | 1 | Value for the select-flag write |
| spw_en | input | 1 | Active pointer write enable |
| spw_data | input | SP_W | Active pointer write data |
| sp_out | output | SP_W | Active stack pointer |
| sel_out | output | 1 | Current select flag |
| lvl_out | output | 2 | Current privilege level |

## Verification
A wrong level or select flag shows up on `lvl_out` and `sel_out` one edge after the request that caused it, and `sp_out` then comes from the wrong bank in the same cycle. A pointer write that lands in the wrong bank shows on `sp_out` only once a later mode change makes that bank active. For this reason the sequence leaves values in every bank and revisits each bank after other banks have been written. Cycles where several requests collide show any fault in the priority order on the next edge.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;

    localparam int unsigned LVL_N = 4;
    localparam int unsigned LVL_W = $clog2(LVL_N);

    typedef logic [LVL_W-1:0] lvl_t;

    // Mode word; also the layout of the restored status word: [2:1] level, [0] select
    typedef struct packed {
        lvl_t lvl;
        logic sel;
    } mode_t;

    localparam mode_t MODE_RST = '{lvl: LVL_W'(LVL_N - 1), sel: 1'b1};

    // Bank index of the pointer in use for a given mode
    function automatic lvl_t bank_of(mode_t m);
        return ((m.lvl == '0) || !m.sel) ? '0 : m.lvl;
    endfunction

endpackage

// File: rtl/sp_mode_ctrl.sv
module sp_mode_ctrl
    import sp_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  exc_take,
    input  lvl_t  exc_tgt,
    input  logic  exc_ret,
    input  mode_t ret_mode,
    input  logic  selw_req,
    input  logic  selw_val,
    output mode_t mode_q
);

    mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (exc_take) begin
            mode_d.lvl = exc_tgt;
            mode_d.sel = 1'b1;
        end else if (exc_ret) begin
            mode_d = ret_mode;
        end else if (selw_req && (mode_q.lvl != '0)) begin
            mode_d.sel = selw_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RST;
        else     mode_q <= mode_d;
    end

endmodule

// File: rtl/sp_regfile.sv
module sp_regfile
    import sp_bank_pkg::*;
#(
    parameter int unsigned SP_W = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  lvl_t                        wr_idx,
    input  logic [SP_W-1:0]             wr_data,
    output logic [LVL_N-1:0][SP_W-1:0]  regs
);

    for (genvar g = 0; g < LVL_N; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == LVL_W'(g)))
                regs[g] <= wr_data;
        end
    end

endmodule

// File: rtl/sp_read_mux.sv
module sp_read_mux
    import sp_bank_pkg::*;
#(
    parameter int unsigned SP_W = 64
) (
    input  logic [LVL_N-1:0][SP_W-1:0] regs,
    input  lvl_t                       idx,
    output logic [SP_W-1:0]            sp
);

    always_comb begin
        sp = '0;
        for (int i = 0; i < LVL_N; i++)
            if (idx == LVL_W'(i)) sp = regs[i];
    end

endmodule

// File: rtl/sp_bank_sel.sv
module sp_bank_sel
    import sp_bank_pkg::*;
#(
    parameter int unsigned SP_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_take,
    input  logic [1:0]       exc_tgt_lvl,
    input  logic             exc_ret,
    input  logic [2:0]       ret_word,
    input  logic             selw_req,
    input  logic             selw_val,
    input  logic             spw_en,
    input  logic [SP_W-1:0]  spw_data,
    output logic [SP_W-1:0]  sp_out,
    output logic             sel_out,
    output logic [1:0]       lvl_out
);

    mode_t                       mode_q;
    lvl_t                        act_idx;
    logic [LVL_N-1:0][SP_W-1:0]  bank;

    sp_mode_ctrl u_mode (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_take),
        .exc_tgt  (lvl_t'(exc_tgt_lvl)),
        .exc_ret  (exc_ret),
        .ret_mode (mode_t'(ret_word)),
        .selw_req (selw_req),
        .selw_val (selw_val),
        .mode_q   (mode_q)
    );

    assign act_idx = bank_of(mode_q);

    sp_regfile #(.SP_W(SP_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (spw_en),
        .wr_idx  (act_idx),
        .wr_data (spw_data),
        .regs    (bank)
    );

    sp_read_mux #(.SP_W(SP_W)) u_mux (
        .regs (bank),
        .idx  (act_idx),
        .sp   (sp_out)
    );

    assign sel_out = mode_q.sel;
    assign lvl_out = mode_q.lvl;

endmodule

// File: rtl/sp_bank_chk.sv
module sp_bank_chk #(
    parameter int unsigned SP_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             exc_take,
    input logic [1:0]       exc_tgt_lvl,
    input logic             exc_ret,
    input logic [2:0]       ret_word,
    input logic             selw_req,
    input logic             selw_val,
    input logic             spw_en,
    input logic [SP_W-1:0]  spw_data,
    input logic [SP_W-1:0]  sp_out,
    input logic             sel_out,
    input logic [1:0]       lvl_out
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lvl_out == 2'd3) && sel_out && (sp_out == '0));

    p_sel_write_r5: assert property (@(posedge clk) disable iff (rst)
        (selw_req && !exc_take && !exc_ret && (lvl_out != 2'd0))
        |=> (sel_out == $past(selw_val)));

    p_lvl0_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (selw_req && !exc_take && !exc_ret && (lvl_out == 2'd0))
        |=> $stable(sel_out));

    p_sp_write_r7: assert property (@(posedge clk) disable iff (rst)
        (spw_en && !exc_take && !exc_ret && !selw_req)
        |=> (sp_out == $past(spw_data)));

    p_entry_r8: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (sel_out && (lvl_out == $past(exc_tgt_lvl))));

    p_return_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_ret && !exc_take)
        |=> ((sel_out == $past(ret_word[0])) && (lvl_out == $past(ret_word[2:1]))));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!spw_en && !exc_take && !exc_ret && !selw_req)
        |=> ($stable(sp_out) && $stable(sel_out) && $stable(lvl_out)));

endmodule

bind sp_bank_sel sp_bank_chk #(.SP_W(SP_W)) u_chk (.*);

// File: tb/sim_sp_bank_sel.sv
`timescale 1ns/1ps
module sim_sp_bank_sel;

    localparam int SP_W = 64;

    typedef struct {
        logic [SP_W-1:0] sp;
        logic            sel;
        logic [1:0]      lvl;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            exc_take = 1'b0;
    logic [1:0]      exc_tgt_lvl = '0;
    logic            exc_ret = 1'b0;
    logic [2:0]      ret_word = '0;
    logic            selw_req = 1'b0;
    logic            selw_val = 1'b0;
    logic            spw_en = 1'b0;
    logic [SP_W-1:0] spw_data = '0;
    logic [SP_W-1:0] sp_out;
    logic            sel_out;
    logic [1:0]      lvl_out;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    logic [SP_W-1:0] m_sp [4];
    logic            m_sel;
    logic [1:0]      m_lvl;

    always #5 clk = ~clk;

    sp_bank_sel #(.SP_W(SP_W)) u0 (.*);

    function automatic int act_bank();
        return (m_lvl == 2'd0 || !m_sel) ? 0 : int'(m_lvl);
    endfunction

    // Driver: one request set per cycle; model updated and expectation queued
    task automatic step(input logic tk, input logic [1:0] tg, input logic rt,
                        input logic [2:0] rw, input logic sw, input logic sv,
                        input logic we, input logic [SP_W-1:0] wd, input string tag);
        exp_t e;
        @(negedge clk);
        exc_take = tk; exc_tgt_lvl = tg; exc_ret = rt; ret_word = rw;
        selw_req = sw; selw_val = sv; spw_en = we; spw_data = wd;
        if (we) m_sp[act_bank()] = wd;
        if (tk) begin
            m_lvl = tg; m_sel = 1'b1;
        end else if (rt) begin
            m_lvl = rw[2:1]; m_sel = rw[0];
        end else if (sw && m_lvl != 2'd0) begin
            m_sel = sv;
        end
        e.sp = m_sp[act_bank()]; e.sel = m_sel; e.lvl = m_lvl; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (sp_out !== e.sp || sel_out !== e.sel || lvl_out !== e.lvl) begin
                fails++;
                $display("FAIL %s: sp=%h sel=%b lvl=%0d expected sp=%h sel=%b lvl=%0d",
                         e.tag, sp_out, sel_out, lvl_out, e.sp, e.sel, e.lvl);
            end
        end
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_sp[i] = '0;
        m_sel = 1'b1; m_lvl = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (sp_out !== '0 || sel_out !== 1'b1 || lvl_out !== 2'd3) begin
            fails++;
            $display("FAIL R1: sp=%h sel=%b lvl=%0d expected sp=0 sel=1 lvl=3",
                     sp_out, sel_out, lvl_out);
        end
        step(0, 0, 0, 0, 0, 0, 1, 64'h1000, "R7 write bank3");
        step(0, 0, 0, 0, 1, 0, 0, 0,        "R5 clear select, R2 bank0 shown");
        step(0, 0, 0, 0, 0, 0, 1, 64'hA0,   "R7 write bank0 via sel0");
        step(0, 0, 0, 0, 1, 1, 0, 0,        "R3 set select, bank3 shown");
        step(0, 0, 1, 3'b011, 0, 0, 0, 0,   "R9 return lvl1 sel1");
        step(0, 0, 0, 0, 0, 0, 1, 64'h111,  "R7 write bank1");
        step(1, 2, 0, 0, 0, 0, 0, 0,        "R8 entry to lvl2");
        step(0, 0, 0, 0, 0, 0, 1, 64'h222,  "R7 write bank2");
        step(0, 0, 1, 3'b001, 0, 0, 0, 0,   "R4 lvl0 with sel1 uses bank0");
        step(0, 0, 0, 0, 1, 0, 0, 0,        "R6 select write at lvl0 ignored");
        step(0, 0, 0, 0, 0, 0, 1, 64'h5,    "R4 write at lvl0 hits bank0");
        step(0, 0, 1, 3'b000, 0, 0, 0, 0,   "R4 lvl0 sel0");
        step(1, 1, 1, 3'b110, 1, 0, 0, 0,   "R10 entry beats return and select");
        step(0, 0, 1, 3'b110, 1, 1, 0, 0,   "R10 return beats select write");
        step(0, 0, 0, 0, 0, 0, 1, 64'h77,   "R2 write at lvl3 sel0 hits bank0");
        step(0, 0, 0, 0, 1, 1, 0, 0,        "R7 bank3 untouched by others");
        step(1, 2, 0, 0, 0, 0, 0, 0,        "R7 bank2 retained");
        step(1, 1, 0, 0, 0, 0, 0, 0,        "R7 bank1 retained");
        step(0, 0, 0, 0, 0, 0, 0, 0,        "R2 idle hold");
        @(negedge clk);
        exc_take = 0; exc_ret = 0; selw_req = 0; spw_en = 0;
        repeat (3) @(posedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule